// File: doc/BRIEF.md
# Packed Byte-Lane Add/Subtract Unit

This block is a combinational execution unit that treats each of its two XLEN-wide source operands (32 or 64 bits, chosen by a parameter) as a row of independent 8-bit lanes. It produces one packed result in which every lane holds the sum or difference of the matching source lanes. No carry or borrow ever crosses a byte boundary. Ten operations are available. Plain add and subtract wrap modulo 256. The halving forms come in signed and unsigned flavours and return the full-precision result shifted right by one. The saturating forms also come in signed and unsigned flavours and clamp each lane to its representable range.

The unit takes a whole 32-bit R-type instruction word and picks the operation from the opcode, funct3 and funct7 fields. It ignores the register-number fields. A word that matches none of the ten encodings raises an illegal flag and forces a zero result. A single clocked bit records, until reset, that a saturating operation clamped at least one lane while the issue strobe was high.

Top module: `pbyte_addsub`

## Requirements
- R1: A word is legal only when bits [6:0] are 1110111, bits [14:12] are 000 and bits [31:25] hold one of the ten funct7 codes: add 0100100, sub 0100101, signed halving add 0000100, signed halving sub 0000101, unsigned halving add 0010100, unsigned halving sub 0010101, signed saturating add 0001100, signed saturating sub 0001101, unsigned saturating add 0011100, unsigned saturating sub 0011101. For any other word, `illegal` is 1 and `result` is all zeros.
- R2: There are XLEN/8 lanes, and lane i uses bits [8i+7:8i] of both sources and of the result. The value of one lane never affects another lane.
- R3: Plain add and plain subtract return the lane sum or difference modulo 256.
- R4: Signed halving add and subtract treat the lanes as two's complement. They return the 9-bit exact result shifted right arithmetically by one, so it truncates toward negative infinity and never rounds up.
- R5: Unsigned halving add and subtract treat the lanes as unsigned. They return the 9-bit exact result shifted right by one, and the sign of the difference becomes the top bit of the result (for example, 0x00 minus 0xFF gives 0x80).
- R6: Signed saturating add and subtract clamp each lane to the range -128..127, giving 0x80 or 0x7F.
- R7: Unsigned saturating add and subtract clamp each lane to the range 0..255, giving 0x00 or 0xFF.
- R8: `sat_flag` is 0 after reset. It becomes 1 on the clock edge after a cycle in which `op_valid` is high and a saturating operation clamps any lane, and it stays 1 until reset.
- R9: Wrap operations, halving operations, illegal words, and any cycle with `op_valid` low never set `sat_flag`.
- R10: Bits [24:15] and [11:7] of `instr` have no effect on `result` or `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky saturation bit |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | High when the current word is really being executed |
| instr | input | 32 | R-type instruction word |
| src_a | input | XLEN | First packed operand |
| src_b | input | XLEN | Second packed operand (subtrahend) |
| result | output | XLEN | Packed lane result, zero for an illegal word |
| illegal | output | 1 | The word matches none of the ten encodings |
| sat_flag | output | 1 | Sticky: some lane has saturated since reset |

## Verification
On every cycle, the assertions check four things: that an illegal word yields a zero result, that a clamping lane holds one of the four boundary values, that the saturation bit never clears once set, and that the saturation bit only rises after a valid clamping operation. Only the bench's scenarios can show the arithmetic itself. To do that, the bench sweeps every operand pair of every operation through the lanes, checks that register-number bits have no effect, and runs the issue sequences that show the flag rising, holding and being cleared by reset.

// File: rtl/pbyte_pkg.sv
package pbyte_pkg;
   typedef enum logic [3:0] {
      OP_NONE, OP_ADD, OP_SUB, OP_HADDS, OP_HSUBS, OP_HADDU, OP_HSUBU,
      OP_SADDS, OP_SSUBS, OP_SADDU, OP_SSUBU
   } pb_op_e;

   localparam logic [6:0] PB_MAJOR  = 7'b1110111;
   localparam logic [2:0] PB_FUNCT3 = 3'b000;
   localparam int         PB_LANE_W = 8;

   function automatic logic pb_is_sat(pb_op_e op);
      return (op == OP_SADDS) || (op == OP_SSUBS) || (op == OP_SADDU) || (op == OP_SSUBU);
   endfunction
endpackage

// File: rtl/pbyte_decode.sv
module pbyte_decode
   import pbyte_pkg::*;
(
   input  logic [31:0] instr,
   output pb_op_e      op,
   output logic        legal
);
   logic [6:0] f7;
   logic       frame_ok;

   assign f7       = instr[31:25];
   assign frame_ok = (instr[6:0] == PB_MAJOR) && (instr[14:12] == PB_FUNCT3);

   always_comb begin
      op = OP_NONE;
      if (frame_ok) begin
         case (f7)
            7'b0100100: op = OP_ADD;
            7'b0100101: op = OP_SUB;
            7'b0000100: op = OP_HADDS;
            7'b0000101: op = OP_HSUBS;
            7'b0010100: op = OP_HADDU;
            7'b0010101: op = OP_HSUBU;
            7'b0001100: op = OP_SADDS;
            7'b0001101: op = OP_SSUBS;
            7'b0011100: op = OP_SADDU;
            7'b0011101: op = OP_SSUBU;
            default:    op = OP_NONE;
         endcase
      end
   end

   assign legal = (op != OP_NONE);
endmodule

// File: rtl/pbyte_lane.sv
module pbyte_lane
   import pbyte_pkg::*;
(
   input  pb_op_e      op,
   input  logic [7:0]  a,
   input  logic [7:0]  b,
   output logic [7:0]  res,
   output logic        sat
);
   logic [8:0] s_sum, s_dif, u_sum, u_dif;

   assign s_sum = {a[7], a} + {b[7], b};
   assign s_dif = {a[7], a} - {b[7], b};
   assign u_sum = {1'b0, a} + {1'b0, b};
   assign u_dif = {1'b0, a} - {1'b0, b};

   always_comb begin
      res = '0;
      sat = 1'b0;
      case (op)
         OP_ADD:   res = u_sum[7:0];
         OP_SUB:   res = u_dif[7:0];
         OP_HADDS: res = s_sum[8:1];
         OP_HSUBS: res = s_dif[8:1];
         OP_HADDU: res = u_sum[8:1];
         OP_HSUBU: res = u_dif[8:1];
         OP_SADDS: begin
            if (s_sum[8] != s_sum[7]) begin
               sat = 1'b1;
               res = s_sum[8] ? 8'h80 : 8'h7F;
            end else res = s_sum[7:0];
         end
         OP_SSUBS: begin
            if (s_dif[8] != s_dif[7]) begin
               sat = 1'b1;
               res = s_dif[8] ? 8'h80 : 8'h7F;
            end else res = s_dif[7:0];
         end
         OP_SADDU: begin
            sat = u_sum[8];
            res = u_sum[8] ? 8'hFF : u_sum[7:0];
         end
         OP_SSUBU: begin
            sat = u_dif[8];
            res = u_dif[8] ? 8'h00 : u_dif[7:0];
         end
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/pbyte_addsub.sv
module pbyte_addsub
   import pbyte_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter bit SHARED_WRAP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic [XLEN-1:0] result,
   output logic            illegal,
   output logic            sat_flag
);
   localparam int              LANES   = XLEN / PB_LANE_W;
   localparam logic [XLEN-1:0] TOPMASK = {LANES{8'h80}};

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("pbyte_addsub: XLEN must be 32 or 64");
   end

   pb_op_e            op;
   logic              legal;
   logic [XLEN-1:0]   lane_word;
   logic [LANES-1:0]  lane_sat;

   pbyte_decode u_dec (
      .instr (instr),
      .op    (op),
      .legal (legal)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pbyte_lane u_lane (
         .op  (op),
         .a   (src_a[PB_LANE_W*i +: PB_LANE_W]),
         .b   (src_b[PB_LANE_W*i +: PB_LANE_W]),
         .res (lane_word[PB_LANE_W*i +: PB_LANE_W]),
         .sat (lane_sat[i])
      );

      // R6
      lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lane_sat[i] |-> (result[PB_LANE_W*i +: PB_LANE_W] == 8'h00 ||
                          result[PB_LANE_W*i +: PB_LANE_W] == 8'h7F ||
                          result[PB_LANE_W*i +: PB_LANE_W] == 8'h80 ||
                          result[PB_LANE_W*i +: PB_LANE_W] == 8'hFF));
   end

   if (SHARED_WRAP) begin : g_wide_wrap
      logic [XLEN-1:0] wide_add, wide_sub;
      assign wide_add = ((src_a & ~TOPMASK) + (src_b & ~TOPMASK)) ^ ((src_a ^ src_b) & TOPMASK);
      assign wide_sub = ((src_a | TOPMASK) - (src_b & ~TOPMASK)) ^ (~(src_a ^ src_b) & TOPMASK);
      always_comb begin
         case (op)
            OP_ADD:  result = wide_add;
            OP_SUB:  result = wide_sub;
            OP_NONE: result = '0;
            default: result = lane_word;
         endcase
      end
   end else begin : g_lane_wrap
      assign result = legal ? lane_word : '0;
   end

   assign illegal = !legal;

   always_ff @(posedge clk) begin
      if (!rst_n)                       sat_flag <= 1'b0;
      else if (op_valid && |lane_sat)   sat_flag <= 1'b1;
   end

   // R1
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (result == '0));

   // R8
   sat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && lane_sat != '0) |=> sat_flag);

   // R8
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sat_flag |=> sat_flag);

   // R9
   sat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_flag && !(op_valid && pb_is_sat(op))) |=> !sat_flag);
endmodule

// File: tb/pbyte_addsub_test.sv
module pbyte_addsub_test;
   localparam int XLEN  = 32;
   localparam int LANES = XLEN / 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [XLEN-1:0] src_a = '0, src_b = '0;
   logic [XLEN-1:0] result;
   logic            illegal, sat_flag;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pbyte_addsub #(.XLEN(XLEN), .SHARED_WRAP(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
      .src_a(src_a), .src_b(src_b), .result(result), .illegal(illegal),
      .sat_flag(sat_flag)
   );

   // op index: 0 add 1 hadd_s 2 hadd_u 3 sadd_s 4 sadd_u 5 sub 6 hsub_s 7 hsub_u 8 ssub_s 9 ssub_u
   function automatic logic [6:0] f7_of(int k);
      case (k)
         0: return 7'b0100100;  1: return 7'b0000100;  2: return 7'b0010100;
         3: return 7'b0001100;  4: return 7'b0011100;  5: return 7'b0100101;
         6: return 7'b0000101;  7: return 7'b0010101;  8: return 7'b0001101;
         default: return 7'b0011101;
      endcase
   endfunction

   function automatic string req_of(int k);
      case (k)
         0, 5: return "R3";
         1, 6: return "R4";
         2, 7: return "R5";
         3, 8: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [7:0] model(int k, logic [7:0] a, logic [7:0] b);
      int sa, sb, ua, ub, r;
      sa = int'($signed(a)); sb = int'($signed(b));
      ua = int'(a);          ub = int'(b);
      case (k)
         0: r = ua + ub;
         1: r = (sa + sb) >>> 1;
         2: r = (ua + ub) >>> 1;
         3: begin r = sa + sb; if (r > 127) r = 127; if (r < -128) r = -128; end
         4: begin r = ua + ub; if (r > 255) r = 255; end
         5: r = ua - ub;
         6: r = (sa - sb) >>> 1;
         7: r = (ua - ub) >>> 1;
         8: begin r = sa - sb; if (r > 127) r = 127; if (r < -128) r = -128; end
         default: begin r = ua - ub; if (r < 0) r = 0; end
      endcase
      return r[7:0];
   endfunction

   function automatic logic [31:0] mk(int k);
      return {f7_of(k), 5'($urandom), 5'($urandom), 3'b000, 5'($urandom), 7'b1110111};
   endfunction

   function automatic bit is_legal(logic [31:0] w);
      if (w[6:0] != 7'b1110111 || w[14:12] != 3'b000) return 1'b0;
      for (int k = 0; k < 10; k++) if (w[31:25] == f7_of(k)) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(int k, logic [7:0] a, logic [7:0] b, string req);
      @(negedge clk);
      instr = mk(k); src_a = {LANES{a}}; src_b = {LANES{b}}; op_valid = 1'b1;
      #2 check(req, result, {LANES{model(k, a, b)}});
      @(negedge clk);
      op_valid = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         finish_run();
      end
   end

   initial begin
      logic [XLEN-1:0] exp_w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8 reset value; R1 zero word is illegal
      check("R8", sat_flag, 0);
      check("R1", {illegal, result}, {1'b1, {XLEN{1'b0}}});

      // full sweep: R2..R7 (lanes get distinct a, b spread across lanes), R10 random reg fields
      @(negedge clk); #2;
      for (int k = 0; k < 10; k++) begin
         for (int a = 0; a < 256; a++) begin
            for (int bb = 0; bb < 64; bb++) begin
               instr = mk(k);
               for (int l = 0; l < LANES; l++) begin
                  src_a[8*l +: 8] = 8'(a + 37 * l);
                  src_b[8*l +: 8] = 8'(bb * 4 + l);
                  exp_w[8*l +: 8] = model(k, 8'(a + 37 * l), 8'(bb * 4 + l));
               end
               #4;
               n_chk++;
               if (result !== exp_w || illegal !== 1'b0) begin
                  n_bad++;
                  $display("FAIL R2/%s/R10 op%0d: actual %h expected %h", req_of(k), k, result, exp_w);
               end
               #1;
            end
         end
      end
      // R9: op_valid low throughout the sweep
      check("R9", sat_flag, 0);

      // R1: random words, legality judged by the bench
      for (int n = 0; n < 400; n++) begin
         logic [31:0] w;
         w = $urandom;
         if (n % 2 == 0) w[6:0] = 7'b1110111;
         if (n % 4 == 0) w[14:12] = 3'b000;
         instr = w; src_a = $urandom; src_b = $urandom;
         #4;
         check("R1", illegal, !is_legal(w));
         if (!is_legal(w)) check("R1", result, 0);
         #1;
      end

      // R8 / R9 flag sequences, using the corner operands
      issue(0, 8'h7F, 8'h01, "R3");   // wraps to 80, no flag
      check("R9", sat_flag, 0);
      issue(1, 8'h7F, 8'h01, "R4");
      check("R9", sat_flag, 0);
      issue(3, 8'h10, 8'h20, "R6");
      check("R8", sat_flag, 0);
      issue(3, 8'h7F, 8'h01, "R6");   // clamps to 7F
      check("R8", sat_flag, 1);
      issue(5, 8'h80, 8'h01, "R3");   // wraps to 7F
      check("R8", sat_flag, 1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; #1;
      check("R8", sat_flag, 0);
      @(negedge clk);
      instr = mk(3); instr[14:12] = 3'b001; src_a = '1; src_b = '1; op_valid = 1'b1;
      #2 check("R1", {illegal, result}, {1'b1, {XLEN{1'b0}}});
      @(negedge clk); op_valid = 1'b0; #1;
      check("R9", sat_flag, 0);
      @(negedge clk);
      instr = mk(8); src_a = {LANES{8'h80}}; src_b = {LANES{8'h01}}; op_valid = 1'b0;
      @(negedge clk); #1;
      check("R9", sat_flag, 0);         // clamping but not valid
      issue(9, 8'h00, 8'hFF, "R7");   // clamps to 00
      check("R8", sat_flag, 1);
      issue(7, 8'h00, 8'hFF, "R5");   // 80
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; #1;
      issue(4, 8'hFF, 8'hFF, "R7");   // clamps to FF
      check("R8", sat_flag, 1);
      issue(2, 8'hFF, 8'hFF, "R5");
      finish_run();
   end
endmodule